// File: doc/BRIEF.md
# Nine-bit SPI command and parameter transmitter

This block drives a display controller over a three-wire serial link (clock, data out, active-low select). Every byte handed to it becomes a 9-bit word: a flag bit that tells the panel whether the byte is a command or a parameter, followed by the 8 byte bits. The flag travels in the bit stream itself, so no separate data/command wire is needed.

The host side is a byte stream with valid and ready. While words keep arriving without a break, the select line stays low and the words follow each other with no gap in the serial clock. A static mode input can force an emulation framing for hosts limited to whole 8-bit transfers. In that mode the burst is made a whole number of bytes long. Eight words fill exactly nine bytes. A shorter tail is completed with zero bits before the select line is released. The serial clock rate is set by a divider parameter.

Top module: `nbs_spi9_tx`

## Requirements
- R1: Each word goes out as the flag bit first, then the 8 data bits with the most significant bit first.
- R2: The flag bit is 0 for a command byte and 1 for a parameter or pixel byte; it is taken from `in_dc` unchanged.
- R3: The serial clock idles low and each half-period lasts exactly DIV clocks. Data out changes only while the serial clock is low and is read by the panel on the rising edge. The serial clock never pulses while select is high.
- R4: If the next word is offered by the end of the current word's last bit, select stays low and the next word's first bit follows with no gap in the serial clock.
- R5: After the final bit of a burst (including any pad bits), the serial clock stays low and select rises exactly one serial clock period (2*DIV clocks) after the last falling edge.
- R6: `in_ready` is high while idle, and during a burst only in the final clock of the high phase of a word's last bit. It is low during padding and during the closing period.
- R7: In emulation mode a burst of 8 words is exactly 72 bits (nine bytes) long, with no pad bits.
- R8: In emulation mode a burst whose bit count is not a multiple of 8 is extended with zero bits up to the next multiple of 8 before select rises.
- R9: In native mode a burst of n words is exactly 9*n bits long, with no pad bits.
- R10: While reset is asserted, select is high, the serial clock and data out are low, and `in_ready` is high.
- R11: The framing mode is taken when a burst starts. A change of `emu_mode` during the burst has no effect until the next burst.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | Byte is accepted when valid and ready are both high |
| in_byte | input | DATA_W | Byte to send |
| in_dc | input | 1 | 0 = command, 1 = parameter/pixel |
| emu_mode | input | 1 | 1 = pad each burst to whole bytes (static setting) |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Active-low select |

## Verification
The end of a word's last bit can fall in the same cycle as two other events: taking the next word, and deciding whether to pad or close the burst. The bench provokes this by holding valid high across a word boundary, by dropping valid exactly there, and by flipping the mode input in the cycle a word is accepted. The reference model in the bench records every accepted word as a list of bits and adds the padding it expects from the mode captured at the burst's first word. It then compares this list with the bits captured on each rising serial clock edge. On every clock it also checks the half-period lengths, the hold of data while the clock is high, the ready pulse and the closing delay.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

   // Sequencer states of the transmitter
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_PAD   = 2'd2,
      ST_TAIL  = 2'd3
   } nbs_state_e;

endpackage

// File: rtl/nbs_clkdiv.sv
module nbs_clkdiv #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk_int,
   output logic bit_end
);

   logic sclk_q;
   logic half_end;

   generate
      if (DIV == 1) begin : g_fast
         // every clock is a half period
         assign half_end = run;
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!run || cnt_q == CW'(DIV - 1))
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end
         assign half_end = run && (cnt_q == CW'(DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sclk_q <= 1'b0;
      else if (!run)
         sclk_q <= 1'b0;
      else if (half_end)
         sclk_q <= ~sclk_q;
   end

   assign sclk_int = sclk_q;
   assign bit_end  = half_end && sclk_q;

   p_idle_low_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !sclk_q);

endmodule

// File: rtl/nbs_shreg.sv
module nbs_shreg #(
   parameter int FRAME_W = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_val,
   input  logic               clr,
   input  logic               shift,
   output logic               msb
);

   logic [FRAME_W-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sr_q <= '0;
      else if (load)
         sr_q <= load_val;
      else if (clr)
         sr_q <= '0;
      else if (shift)
         sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
   end

   assign msb = sr_q[FRAME_W-1];

   p_load_msb_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (msb == $past(load_val[FRAME_W-1])));

endmodule

// File: rtl/nbs_ctrl.sv
module nbs_ctrl
   import nbs_pkg::*;
#(
   parameter int FRAME_W = 9,
   parameter bit EMU_EN  = 1'b1,
   parameter int HOST_W  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic emu_mode,
   input  logic bit_end,
   output logic in_ready,
   output logic load,
   output logic shift,
   output logic clr,
   output logic run,
   output logic clk_gate,
   output logic cs_n,
   output logic pad_active
);

   localparam int BW = $clog2(FRAME_W);

   nbs_state_e    st_q, st_d;
   logic [BW-1:0] idx_q;
   logic          last_bit;
   logic          accept;
   logic          cnt_en;
   logic          pad_mode;
   logic          grp_next_aligned;
   logic          grp_now_aligned;

   assign last_bit = (idx_q == BW'(FRAME_W - 1));
   assign in_ready = (st_q == ST_IDLE) || (st_q == ST_SHIFT && last_bit && bit_end);
   assign accept   = in_ready && in_valid;
   assign load     = accept;

   // tracker of bits sent modulo the host byte, only when emulation exists
   generate
      if (EMU_EN) begin : g_emu
         localparam int MW = $clog2(HOST_W);
         logic [MW-1:0] m_q;
         logic          mode_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               m_q    <= '0;
               mode_q <= 1'b0;
            end else if (st_q == ST_IDLE && accept) begin
               m_q    <= '0;
               mode_q <= emu_mode;
            end else if (cnt_en) begin
               m_q    <= m_q + 1'b1;
            end
         end
         assign pad_mode         = mode_q;
         assign grp_next_aligned = (m_q + 1'b1) == '0;
         assign grp_now_aligned  = (m_q == '0);
      end else begin : g_native
         logic unused_mode;
         assign unused_mode      = emu_mode;
         assign pad_mode         = 1'b0;
         assign grp_next_aligned = 1'b1;
         assign grp_now_aligned  = 1'b1;
      end
   endgenerate

   always_comb begin
      st_d   = st_q;
      shift  = 1'b0;
      clr    = 1'b0;
      cnt_en = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (accept) st_d = ST_SHIFT;
         end
         ST_SHIFT: begin
            if (bit_end) begin
               cnt_en = 1'b1;
               if (!last_bit) begin
                  shift = 1'b1;
               end else if (!in_valid) begin
                  clr  = 1'b1;
                  st_d = (pad_mode && !grp_next_aligned) ? ST_PAD : ST_TAIL;
               end
            end
         end
         ST_PAD: begin
            if (bit_end) begin
               cnt_en = 1'b1;
               if (grp_next_aligned) begin
                  clr  = 1'b1;
                  st_d = ST_TAIL;
               end
            end
         end
         ST_TAIL: begin
            if (bit_end) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         idx_q <= '0;
      end else begin
         st_q <= st_d;
         if (accept)
            idx_q <= '0;
         else if (shift)
            idx_q <= idx_q + 1'b1;
      end
   end

   assign run        = (st_q != ST_IDLE);
   assign clk_gate   = (st_q == ST_SHIFT) || (st_q == ST_PAD);
   assign cs_n       = (st_q == ST_IDLE);
   assign pad_active = (st_q == ST_PAD);

   // padding only happens in emulation framing
   p_pad_needs_emu_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PAD) |-> pad_mode);

   // the closing period of an emulated burst starts on a byte boundary
   p_tail_aligned_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_TAIL && pad_mode) |-> grp_now_aligned);

   // ready is never offered during padding or the closing period
   p_ready_quiet_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PAD || st_q == ST_TAIL) |-> !in_ready);

endmodule

// File: rtl/nbs_spi9_tx.sv
module nbs_spi9_tx #(
   parameter int DATA_W = 8,
   parameter int DIV    = 2,
   parameter bit EMU_EN = 1'b1,
   parameter int HOST_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_byte,
   input  logic              in_dc,
   input  logic              emu_mode,
   output logic              spi_sclk,
   output logic              spi_mosi,
   output logic              spi_cs_n
);

   localparam int FRAME_W = DATA_W + 1;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("nbs_spi9_tx: DATA_W must be at least 1");
      end
      if (DIV < 1) begin : g_bad_div
         $error("nbs_spi9_tx: DIV must be at least 1");
      end
      if (HOST_W < 2 || (HOST_W & (HOST_W - 1)) != 0) begin : g_bad_host
         $error("nbs_spi9_tx: HOST_W must be a power of two");
      end
   endgenerate

   logic sclk_int;
   logic bit_end;
   logic load;
   logic shift;
   logic clr;
   logic run;
   logic clk_gate;
   logic pad_active;

   nbs_ctrl #(
      .FRAME_W (FRAME_W),
      .EMU_EN  (EMU_EN),
      .HOST_W  (HOST_W)
   ) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .emu_mode   (emu_mode),
      .bit_end    (bit_end),
      .in_ready   (in_ready),
      .load       (load),
      .shift      (shift),
      .clr        (clr),
      .run        (run),
      .clk_gate   (clk_gate),
      .cs_n       (spi_cs_n),
      .pad_active (pad_active)
   );

   nbs_clkdiv #(
      .DIV (DIV)
   ) div_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .sclk_int (sclk_int),
      .bit_end  (bit_end)
   );

   nbs_shreg #(
      .FRAME_W (FRAME_W)
   ) sr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val ({in_dc, in_byte}),
      .clr      (clr),
      .shift    (shift),
      .msb      (spi_mosi)
   );

   assign spi_sclk = sclk_int && clk_gate;

   p_no_clock_idle_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);

   p_mosi_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

   p_pad_zero_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      pad_active |-> !spi_mosi);

   p_ready_at_edge_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !spi_cs_n) |-> spi_sclk);

   p_release_low_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> !$past(spi_sclk));

endmodule

// File: tb/nbs_spi9_tx_tb_top.sv
module nbs_spi9_tx_tb_top;

   localparam int DIV    = 2;
   localparam int DATA_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [DATA_W-1:0] in_byte = '0;
   logic              in_dc = 1'b0;
   logic              emu_mode = 1'b0;
   logic              spi_sclk;
   logic              spi_mosi;
   logic              spi_cs_n;

   int vectors = 0;
   int miscompares = 0;
   int last_len = 0;
   int bursts_done = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   nbs_spi9_tx #(.DATA_W(DATA_W), .DIV(DIV), .EMU_EN(1'b1), .HOST_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_byte(in_byte), .in_dc(in_dc), .emu_mode(emu_mode),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // reference model state
   bit exp_q[$];
   bit got_q[$];
   bit bursting = 1'b0;
   bit burst_mode = 1'b0;
   bit prev_sclk = 1'b0;
   bit prev_cs = 1'b1;
   bit prev_mosi = 1'b0;
   int lowcnt = 0;
   int highcnt = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         chk(spi_cs_n == 1'b1, "R10 cs_n", int'(spi_cs_n), 1);
         chk(spi_sclk == 1'b0, "R10 sclk", int'(spi_sclk), 0);
         chk(spi_mosi == 1'b0, "R10 mosi", int'(spi_mosi), 0);
         chk(in_ready == 1'b1, "R10 ready", int'(in_ready), 1);
      end else begin
         // R3: no clock while deselected, data held while clock high
         chk(!(spi_cs_n && spi_sclk), "R3 sclk idle", int'(spi_sclk), 0);
         if (spi_sclk && prev_sclk)
            chk(spi_mosi == prev_mosi, "R3 mosi hold", int'(spi_mosi), int'(prev_mosi));
         // R6: ready pattern
         if (spi_cs_n)
            chk(in_ready, "R6 idle ready", int'(in_ready), 1);
         else if (in_ready)
            chk(spi_sclk, "R6 ready edge", int'(spi_sclk), 1);
         // burst end: R5, R7, R8, R9, R1, R2, R11
         if (spi_cs_n && !prev_cs) begin
            chk(lowcnt == 2 * DIV, "R5 release delay", lowcnt, 2 * DIV);
            if (burst_mode)
               while ((exp_q.size() % 8) != 0) exp_q.push_back(1'b0);
            chk(got_q.size() == exp_q.size(), "R8/R9 burst length",
                got_q.size(), exp_q.size());
            for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
               chk(got_q[i] == exp_q[i], "R1 bit value", int'(got_q[i]), int'(exp_q[i]));
            last_len = got_q.size();
            bursts_done++;
            got_q.delete();
            exp_q.delete();
            bursting = 1'b0;
         end
         // acceptance of a word
         if (in_ready && in_valid) begin
            if (!bursting) begin
               bursting = 1'b1;
               burst_mode = emu_mode;
            end
            exp_q.push_back(in_dc);
            for (int b = DATA_W - 1; b >= 0; b--) exp_q.push_back(in_byte[b]);
         end
         // phase lengths and bit capture
         if (!spi_cs_n && prev_cs) begin
            lowcnt = 1;
         end else if (spi_sclk && !prev_sclk) begin
            chk(lowcnt == DIV, "R3 low phase", lowcnt, DIV);
            got_q.push_back(spi_mosi);
            highcnt = 1;
         end else if (spi_sclk) begin
            highcnt++;
         end else if (prev_sclk) begin
            chk(highcnt == DIV, "R3 high phase", highcnt, DIV);
            lowcnt = 1;
         end else if (!spi_cs_n) begin
            lowcnt++;
         end
      end
      prev_sclk = spi_sclk;
      prev_cs   = spi_cs_n;
      prev_mosi = spi_mosi;
   end

   // send n words back-to-back; flip the mode after the first acceptance if asked
   task automatic send_burst(input int n, input bit mode, input bit flip, input int seed);
      @(posedge clk); #2;
      emu_mode = mode;
      for (int w = 0; w < n; w++) begin
         in_valid = 1'b1;
         in_byte  = DATA_W'((seed * 37 + w * 91 + 5) & 8'hFF);
         in_dc    = (w != 0);
         forever begin
            @(negedge clk);
            if (in_ready) break;
         end
         @(posedge clk); #2;
         if (flip && w == 0) emu_mode = ~mode;
      end
      in_valid = 1'b0;
      forever begin
         @(negedge clk);
         if (spi_cs_n && !bursting) break;
      end
   endtask

   task automatic expect_len(input int exp, input string req);
      chk(last_len == exp, req, last_len, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      @(posedge clk); #2;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      send_burst(1, 1'b0, 1'b0, 1);  expect_len(9,  "R9 single native");     // R2 command flag
      send_burst(3, 1'b0, 1'b0, 2);  expect_len(27, "R9 three native");       // R4 gapless
      send_burst(8, 1'b1, 1'b0, 3);  expect_len(72, "R7 eight emulated");
      send_burst(3, 1'b1, 1'b0, 4);  expect_len(32, "R8 three emulated");
      send_burst(1, 1'b1, 1'b0, 5);  expect_len(16, "R8 one emulated");
      send_burst(10, 1'b1, 1'b0, 6); expect_len(96, "R8 ten emulated");
      send_burst(2, 1'b1, 1'b1, 7);  expect_len(24, "R11 mode held emulated");
      send_burst(2, 1'b0, 1'b1, 8);  expect_len(18, "R11 mode held native");
      send_burst(1, 1'b0, 1'b0, 9);  expect_len(9,  "R9 after gap");
      chk(bursts_done == 9, "R4 burst count", bursts_done, 9);
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (150000) @(posedge clk);
            chk(1'b0, "watchdog", 0, 1);
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule